// File: doc/BRIEF.md
# I2C Target Controller with Automatic Status Flags

This block is the target side of a two-wire serial bus. It watches the clock and data lines, picks out START and STOP conditions, and decodes the 7-bit address that follows each START. The address is compared against a programmable own address and against the all-zero general call address. A write access from the bus controller fills a receive holding register. A read access is served from a transmit holding register, and the block sends all-ones when that register is empty. Both bus lines are open drain. The block samples each line as an input and pulls it low through an enable. SCL is never driven.

Local logic works through a narrow register port. It writes the transmit holding register, reads the receive holding register, and watches a seven-bit status vector. Every status flag sets and clears by itself on bus events and on holding-register accesses. Software therefore never writes a flag directly. Reading the status vector has no side effects.

Top module: `i2c_target_flags`

## Requirements
- R1: An address byte whose upper seven bits equal `own_addr`, or a byte of 0x00, is acknowledged by holding SDA low for the ninth clock. Any other address byte is not acknowledged, and SDA is not driven for that byte or for any later byte until the next START.
- R2: Status bit 4 (addressed) sets when the own address matches. It clears on a STOP, on a NACK from the controller during a read, or on an address that matches neither own address nor general call.
- R3: Status bit 3 (read direction) takes the R/W bit (bit 0, 1 = read) of each address byte that matches the own address, and keeps that value until the next such match.
- R4: Write bytes are taken MSB first and acknowledged. Each completed byte is placed in `rhr_data` and sets status bit 1 (receive ready). A one-cycle `rhr_rd` pulse clears that bit.
- R5: Read bytes are sent MSB first from the value written through `thr_wr`/`thr_data`. Status bit 2 (transmit ready, 1 after reset) clears on an accepted write. It sets again only once that byte has been sent and the controller has answered with either ACK or NACK.
- R6: A read byte that begins while no written byte is waiting is sent as 0xFF.
- R7: A NACK from the controller on a read byte sets status bit 6 (NACK) and stops transmission. SDA is then released and stays released until the next START.
- R8: While status bits 2 and 6 are both 1, `thr_wr` is ignored. Status bit 2 stays 1, and the written value is never transmitted.
- R9: Status bit 6 clears on the next START or own-address match.
- R10: Status bit 0 (complete, 1 after reset) clears on START. It sets on STOP, or on an address after a START or repeated START that matches neither own address nor general call.
- R11: A general call (address byte 0x00) sets status bit 5 and leaves status bit 4 at 0. The bytes that follow are received as in R4. Status bit 5 clears on the next START or STOP.
- R12: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high, both seen on the synchronized lines. After reset the status vector is 0x05 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| own_addr | input | 7 | Programmed 7-bit target address |
| scl_i | input | 1 | Sensed level of the bus clock line |
| sda_i | input | 1 | Sensed level of the bus data line |
| sda_oe | output | 1 | Pull the data line low when 1 |
| thr_wr | input | 1 | Write strobe for the transmit holding register |
| thr_data | input | 8 | Byte to transmit |
| rhr_rd | input | 1 | Read strobe for the receive holding register |
| rhr_data | output | 8 | Last received byte |
| status | output | 7 | Flags: 0 complete, 1 rx ready, 2 tx ready, 3 read dir, 4 addressed, 5 general call, 6 NACK |

## Verification
The hardest state to reach is the lock-out where transmit-ready and NACK are both high. Reaching it takes a full read access. The controller first acknowledges a loaded byte, then refuses a filler byte, and only after that does the host attempt a write. The bench then opens a fresh read access and expects 0xFF, which shows that the refused write never reached the shifter. A repeated START carrying a foreign address, issued in the middle of a write access, exercises the second path that sets the complete flag and clears the addressed flag.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam int STAT_W = 7;

  localparam int SB_DONE = 0;
  localparam int SB_RXR  = 1;
  localparam int SB_TXR  = 2;
  localparam int SB_DIR  = 3;
  localparam int SB_ACC  = 4;
  localparam int SB_GC   = 5;
  localparam int SB_NAK  = 6;

  typedef enum logic [2:0] {
    L_IDLE, L_ADDR, L_RX, L_ACK, L_TX, L_TACK
  } link_t;

  function automatic logic own_hit(input logic [BYTE_W-1:0] b,
                                   input logic [ADDR_W-1:0] own);
    return b[BYTE_W-1:1] == own;
  endfunction

  function automatic logic gcall_hit(input logic [BYTE_W-1:0] b);
    return b == '0;
  endfunction

  function automatic logic [BYTE_W-1:0] tx_pick(input logic valid,
                                                input logic [BYTE_W-1:0] d);
    return valid ? d : '1;
  endfunction
endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic start_ev,
  output logic stop_ev,
  output logic scl_rise,
  output logic scl_fall
);
  localparam int ST = (STAGES < 2) ? 2 : STAGES;

  logic [ST-1:0] scl_ff, sda_ff;
  logic scl_s, scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[ST-2:0], scl_i};
      sda_ff <= {sda_ff[ST-2:0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  assign scl_s    = scl_ff[ST-1];
  assign sda_s    = sda_ff[ST-1];
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
endmodule

// File: rtl/i2ct_link.sv
module i2ct_link
  import i2ct_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              sda_oe,
  output logic              addr_own,
  output logic              addr_gc,
  output logic              addr_miss,
  output logic              rw_bit,
  output logic              rx_done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              tx_load,
  output logic              tx_acked,
  output logic              tx_nacked
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  link_t             st;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh;
  logic              to_tx;
  logic              byte_in, addr_end, hit_own, hit_gc;

  assign byte_in   = (cnt == FULL);
  assign addr_end  = (st == L_ADDR) && scl_fall && byte_in;
  assign hit_gc    = gcall_hit(sh);
  assign hit_own   = own_hit(sh, own_addr) && !hit_gc;
  assign addr_gc   = addr_end && hit_gc;
  assign addr_own  = addr_end && hit_own;
  assign addr_miss = addr_end && !hit_own && !hit_gc;
  assign rw_bit    = sh[0];
  assign rx_byte   = sh;
  assign rx_done   = (st == L_RX) && scl_fall && byte_in;
  assign tx_load   = scl_fall && (((st == L_ACK) && to_tx) || (st == L_TACK));
  assign tx_acked  = (st == L_TACK) && scl_rise && !sda_s;
  assign tx_nacked = (st == L_TACK) && scl_rise && sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= L_IDLE;
      cnt    <= '0;
      sh     <= '0;
      to_tx  <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start_ev) begin
      st     <= L_ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_ev) begin
      st     <= L_IDLE;
      sda_oe <= 1'b0;
    end else begin
      unique case (st)
        L_ADDR, L_RX: begin
          if (scl_rise && !byte_in) begin
            sh  <= {sh[BYTE_W-2:0], sda_s};
            cnt <= cnt + 1'b1;
          end else if (scl_fall && byte_in) begin
            if ((st == L_RX) || hit_own || hit_gc) begin
              sda_oe <= 1'b1;
              st     <= L_ACK;
              to_tx  <= (st == L_ADDR) && hit_own && sh[0];
            end else begin
              st <= L_IDLE;
            end
          end
        end
        L_ACK: begin
          if (scl_fall) begin
            cnt <= '0;
            if (to_tx) begin
              sh     <= tx_byte;
              sda_oe <= !tx_byte[BYTE_W-1];
              st     <= L_TX;
            end else begin
              sda_oe <= 1'b0;
              st     <= L_RX;
            end
          end
        end
        L_TX: begin
          if (scl_fall) begin
            if (cnt == LAST) begin
              sda_oe <= 1'b0;
              st     <= L_TACK;
            end else begin
              sh     <= {sh[BYTE_W-2:0], 1'b0};
              sda_oe <= !sh[BYTE_W-2];
              cnt    <= cnt + 1'b1;
            end
          end
        end
        L_TACK: begin
          if (scl_rise && sda_s) begin
            st <= L_IDLE;
          end else if (scl_fall) begin
            sh     <= tx_byte;
            sda_oe <= !tx_byte[BYTE_W-1];
            cnt    <= '0;
            st     <= L_TX;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_target_flags.sv
module i2c_target_flags
  import i2ct_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              thr_wr,
  input  logic [BYTE_W-1:0] thr_data,
  input  logic              rhr_rd,
  output logic [BYTE_W-1:0] rhr_data,
  output logic [STAT_W-1:0] status
);
  logic sda_s, start_ev, stop_ev, scl_rise, scl_fall;
  logic addr_own, addr_gc, addr_miss, rw_bit, rx_done;
  logic tx_load, tx_acked, tx_nacked, tx_answered, thr_wr_ok;
  logic [BYTE_W-1:0] rx_byte, tx_byte, thr_q;
  logic thr_valid, in_flight;
  logic f_done, f_rxr, f_txr, f_dir, f_acc, f_gc, f_nak;

  i2ct_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .start_ev(start_ev), .stop_ev(stop_ev),
    .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  i2ct_link u_link (
    .clk(clk), .rst_n(rst_n), .start_ev(start_ev), .stop_ev(stop_ev),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
    .own_addr(own_addr), .tx_byte(tx_byte), .sda_oe(sda_oe),
    .addr_own(addr_own), .addr_gc(addr_gc), .addr_miss(addr_miss),
    .rw_bit(rw_bit), .rx_done(rx_done), .rx_byte(rx_byte),
    .tx_load(tx_load), .tx_acked(tx_acked), .tx_nacked(tx_nacked)
  );

  assign tx_byte     = tx_pick(thr_valid, thr_q);
  assign thr_wr_ok   = thr_wr && !(f_txr && f_nak);
  assign tx_answered = tx_acked || tx_nacked;

  // holding registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q     <= '0;
      thr_valid <= 1'b0;
      in_flight <= 1'b0;
      rhr_data  <= '0;
    end else begin
      if (tx_load) begin
        in_flight <= thr_valid;
        thr_valid <= 1'b0;
      end else if (tx_answered) begin
        in_flight <= 1'b0;
      end
      if (thr_wr_ok) begin
        thr_q     <= thr_data;
        thr_valid <= 1'b1;
      end
      if (rx_done) rhr_data <= rx_byte;
    end
  end

  // status flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_done <= 1'b1;
      f_rxr  <= 1'b0;
      f_txr  <= 1'b1;
      f_dir  <= 1'b0;
      f_acc  <= 1'b0;
      f_gc   <= 1'b0;
      f_nak  <= 1'b0;
    end else begin
      if (start_ev) f_done <= 1'b0;
      else if (stop_ev || addr_miss) f_done <= 1'b1;

      if (rx_done) f_rxr <= 1'b1;
      else if (rhr_rd) f_rxr <= 1'b0;

      if (thr_wr_ok) f_txr <= 1'b0;
      else if (tx_answered && in_flight && !thr_valid) f_txr <= 1'b1;

      if (addr_own) f_dir <= rw_bit;

      if (addr_own) f_acc <= 1'b1;
      else if (stop_ev || tx_nacked || addr_miss) f_acc <= 1'b0;

      if (addr_gc) f_gc <= 1'b1;
      else if (start_ev || stop_ev) f_gc <= 1'b0;

      if (tx_nacked) f_nak <= 1'b1;
      else if (start_ev || addr_own) f_nak <= 1'b0;
    end
  end

  always_comb begin
    status         = '0;
    status[SB_DONE] = f_done;
    status[SB_RXR]  = f_rxr;
    status[SB_TXR]  = f_txr;
    status[SB_DIR]  = f_dir;
    status[SB_ACC]  = f_acc;
    status[SB_GC]   = f_gc;
    status[SB_NAK]  = f_nak;
  end
endmodule

// File: rtl/i2ct_check.sv
module i2ct_check
  import i2ct_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sda_oe,
  input logic [STAT_W-1:0] status,
  input logic              thr_wr,
  input logic              rhr_rd,
  input logic              start_ev,
  input logic              stop_ev,
  input logic              addr_own,
  input logic              addr_gc,
  input logic              addr_miss,
  input logic              rx_done,
  input logic              tx_nacked
);
  assert_addr_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({addr_own, addr_gc, addr_miss}));

  assert_release_on_stop_R12: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe);

  assert_acc_drop_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !status[SB_ACC]);

  assert_rx_ready_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> status[SB_RXR]);

  assert_rx_ready_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rhr_rd && !rx_done) |=> !status[SB_RXR]);

  assert_nack_halts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_nacked |=> status[SB_NAK] && !status[SB_ACC] && !sda_oe);

  assert_locked_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr && status[SB_TXR] && status[SB_NAK]) |=> status[SB_TXR]);

  assert_start_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !status[SB_NAK] && !status[SB_DONE]);

  assert_miss_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    addr_miss |=> status[SB_DONE] && !status[SB_ACC]);

  assert_gc_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    addr_gc |=> status[SB_GC] && !status[SB_ACC]);
endmodule

bind i2c_target_flags i2ct_check u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .status(status),
  .thr_wr(thr_wr), .rhr_rd(rhr_rd), .start_ev(start_ev), .stop_ev(stop_ev),
  .addr_own(addr_own), .addr_gc(addr_gc), .addr_miss(addr_miss),
  .rx_done(rx_done), .tx_nacked(tx_nacked)
);

// File: tb/sim_i2c_target_flags.sv
`timescale 1ns/1ps
module sim_i2c_target_flags;
  localparam int H = 10;
  localparam int Q = 5;
  localparam int S_DONE = 0, S_RXR = 1, S_TXR = 2, S_DIR = 3, S_ACC = 4, S_GC = 5, S_NAK = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [6:0] own_addr = 7'h3A;
  logic m_scl = 1'b1;
  logic m_sda_low = 1'b0;
  logic sda_oe;
  logic sda_line;
  logic thr_wr = 1'b0;
  logic [7:0] thr_data = 8'h00;
  logic rhr_rd = 1'b0;
  logic [7:0] rhr_data;
  logic [6:0] status;

  assign sda_line = !(m_sda_low || sda_oe);

  i2c_target_flags u0 (
    .clk(clk), .rst_n(rst_n), .own_addr(own_addr), .scl_i(m_scl),
    .sda_i(sda_line), .sda_oe(sda_oe), .thr_wr(thr_wr), .thr_data(thr_data),
    .rhr_rd(rhr_rd), .rhr_data(rhr_data), .status(status)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic cmp_en = 1'b0;
  logic [6:0] exp_st = 7'h05;
  logic finished = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference status model compared every clock while the bus is quiet
  always @(negedge clk) begin
    if (cmp_en) chk("R12 status model", int'(status), int'(exp_st));
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiet();
    cmp_en = 1'b0;
  endtask

  task automatic settle();
    wait_clk(8);
    cmp_en = 1'b1;
    wait_clk(2);
  endtask

  task automatic bit_out(input logic b);
    wait_clk(Q); m_sda_low = !b;
    wait_clk(Q); m_scl = 1'b1;
    wait_clk(H); m_scl = 1'b0;
  endtask

  task automatic bit_in(output logic b);
    wait_clk(Q); m_sda_low = 1'b0;
    wait_clk(Q); m_scl = 1'b1;
    wait_clk(Q); b = sda_line;
    wait_clk(Q); m_scl = 1'b0;
  endtask

  task automatic m_start();
    quiet();
    if (!m_scl) begin
      wait_clk(Q); m_sda_low = 1'b0;
      wait_clk(Q); m_scl = 1'b1;
      wait_clk(H);
    end
    m_sda_low = 1'b1;
    wait_clk(H); m_scl = 1'b0;
  endtask

  task automatic m_stop();
    quiet();
    wait_clk(Q); m_sda_low = 1'b1;
    wait_clk(Q); m_scl = 1'b1;
    wait_clk(H); m_sda_low = 1'b0;
    wait_clk(H);
  endtask

  task automatic m_wbyte(input logic [7:0] b, output logic ack);
    logic x;
    quiet();
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(x);
    ack = !x;
  endtask

  task automatic m_rbyte(input logic give_ack, output logic [7:0] b);
    logic x;
    quiet();
    for (int i = 7; i >= 0; i--) begin
      bit_in(x);
      b[i] = x;
    end
    bit_out(!give_ack);
  endtask

  task automatic host_wr(input logic [7:0] d);
    quiet();
    thr_data = d; thr_wr = 1'b1;
    @(negedge clk); thr_wr = 1'b0;
  endtask

  task automatic host_rd(input string tag, input logic [7:0] exp);
    quiet();
    chk(tag, int'(rhr_data), int'(exp));
    rhr_rd = 1'b1;
    @(negedge clk); rhr_rd = 1'b0;
    exp_st[S_RXR] = 1'b0;
  endtask

  initial begin
    logic a;
    logic [7:0] d;
    wait_clk(4); rst_n = 1'b1; wait_clk(4);
    chk("R12 reset status", int'(status), 'h05);
    chk("R12 reset sda released", int'(sda_oe), 0);
    settle();

    // write access to own address, two bytes
    m_start(); exp_st[S_DONE] = 1'b0;
    m_wbyte(8'h74, a); chk("R1 own address ack", int'(a), 1);
    exp_st[S_ACC] = 1'b1; exp_st[S_DIR] = 1'b0; settle();
    chk("R2 addressed set", int'(status[S_ACC]), 1);
    m_wbyte(8'hA5, a); chk("R4 data ack", int'(a), 1);
    exp_st[S_RXR] = 1'b1; settle();
    chk("R4 rx ready set", int'(status[S_RXR]), 1);
    host_rd("R4 first byte", 8'hA5); settle();
    chk("R4 rx ready cleared by read", int'(status[S_RXR]), 0);
    m_wbyte(8'h5C, a); exp_st[S_RXR] = 1'b1;
    m_stop(); exp_st[S_ACC] = 1'b0; exp_st[S_DONE] = 1'b1; settle();
    chk("R10 done after stop", int'(status[S_DONE]), 1);
    host_rd("R4 second byte", 8'h5C); settle();

    // foreign address is ignored
    m_start(); exp_st[S_DONE] = 1'b0;
    m_wbyte(8'h22, a); chk("R1 foreign address no ack", int'(a), 0);
    exp_st[S_DONE] = 1'b1; settle();
    m_wbyte(8'h00, a); chk("R1 later byte not acked", int'(a), 0);
    settle();
    chk("R1 rx ready untouched", int'(status[S_RXR]), 0);
    m_stop(); settle();

    // read access: loaded byte, then filler with NACK
    host_wr(8'h96); exp_st[S_TXR] = 1'b0; settle();
    chk("R5 tx ready cleared by write", int'(status[S_TXR]), 0);
    m_start(); exp_st[S_DONE] = 1'b0;
    m_wbyte(8'h75, a); chk("R1 read address ack", int'(a), 1);
    exp_st[S_ACC] = 1'b1; exp_st[S_DIR] = 1'b1; settle();
    chk("R3 read direction", int'(status[S_DIR]), 1);
    m_rbyte(1'b1, d); chk("R5 loaded byte sent", int'(d), 'h96);
    exp_st[S_TXR] = 1'b1; settle();
    chk("R5 tx ready after ack", int'(status[S_TXR]), 1);
    m_rbyte(1'b0, d); chk("R6 filler byte", int'(d), 'hFF);
    exp_st[S_NAK] = 1'b1; exp_st[S_ACC] = 1'b0; settle();
    chk("R7 nack flag", int'(status[S_NAK]), 1);
    chk("R7 sda released after nack", int'(sda_oe), 0);
    host_wr(8'h12); settle();
    chk("R8 write ignored", int'(status[S_TXR]), 1);
    m_stop(); exp_st[S_DONE] = 1'b1; settle();

    // new read: lock-out byte must not appear
    m_start(); exp_st[S_DONE] = 1'b0; exp_st[S_NAK] = 1'b0; settle();
    chk("R9 nack cleared by start", int'(status[S_NAK]), 0);
    m_wbyte(8'h75, a); exp_st[S_ACC] = 1'b1;
    m_rbyte(1'b0, d); chk("R8 ignored byte not sent", int'(d), 'hFF);
    exp_st[S_NAK] = 1'b1; exp_st[S_ACC] = 1'b0; settle();
    m_stop(); exp_st[S_DONE] = 1'b1; settle();

    // repeated start with a foreign address
    m_start(); exp_st[S_DONE] = 1'b0; exp_st[S_NAK] = 1'b0;
    m_wbyte(8'h74, a); exp_st[S_ACC] = 1'b1; exp_st[S_DIR] = 1'b0; settle();
    chk("R3 write direction", int'(status[S_DIR]), 0);
    m_wbyte(8'h42, a); exp_st[S_RXR] = 1'b1;
    m_start();
    m_wbyte(8'h22, a); chk("R1 foreign after repeat start", int'(a), 0);
    exp_st[S_DONE] = 1'b1; exp_st[S_ACC] = 1'b0; settle();
    chk("R10 done after foreign repeat", int'(status[S_DONE]), 1);
    chk("R2 addressed cleared by miss", int'(status[S_ACC]), 0);
    m_stop(); settle();
    host_rd("R4 byte before repeat", 8'h42); settle();

    // general call
    m_start(); exp_st[S_DONE] = 1'b0;
    m_wbyte(8'h00, a); chk("R11 general call ack", int'(a), 1);
    exp_st[S_GC] = 1'b1; settle();
    chk("R11 gc flag without addressed", int'(status[S_ACC]), 0);
    m_wbyte(8'h06, a); chk("R11 command ack", int'(a), 1);
    exp_st[S_RXR] = 1'b1;
    m_stop(); exp_st[S_GC] = 1'b0; exp_st[S_DONE] = 1'b1; settle();
    host_rd("R11 command byte", 8'h06); settle();

    quiet();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule